// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream port. Software reaches both through a 16-bit word access port with per-byte enables. Reads are combinational. Writes are taken at the rising clock edge.

A management agent registers one downstream device by its address. After that, plug and unplug strobes carrying an address update the presence and event bits in slot status, but only when the address matches the registered device.

Two kinds of event can request an interrupt:
- a command-completed event, from a control write that changes the stored value;
- a hot-plug event, from a matching plug or unplug.

Each kind is gated by its own enable bits in slot control. Both are qualified by an external interrupt-enable input. The request leaves the block as a registered pulse that lasts one clock.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, slot control reads 0x03C0, slot status reads 0x0000 and `irq_pulse` is low.
- R2: Slot control (offset 0x18) is written only when `reg_be` is 2'b11. A write with any other byte-enable value leaves slot control unchanged and raises no event.
- R3: A full-word control write whose data differs from the stored value sets command-completed (status bit 0x0010). A write of the same value changes nothing.
- R4: A command-completed event requests an interrupt only when control bit 0x0010 is set in the newly written value.
- R5: A plug strobe whose address matches the registered device sets status bits 0x0040 (presence), 0x0008 (presence changed) and 0x0001 (attention button).
- R6: A matching unplug strobe clears status bit 0x0040 and sets bits 0x0008 and 0x0001.
- R7: Plug and unplug strobes have no effect when no device is registered, or when their address differs from the registered one.
- R8: After a matching plug or unplug, an interrupt is requested only if control bit 0x0020 is set and (status AND control AND 0x0009) is nonzero. Both values are taken after the update.
- R9: `irq_pulse` rises in the cycle after the causing edge, lasts one cycle per request, and never rises while `irq_en` was low at that edge.
- R10: A write to slot status (offset 0x1A) clears those of bits 0x011B that are written as one, within the enabled bytes. Bit 0x0040 is read-only. All other status bits read as zero.
- R11: When a status write and a matching plug or unplug fall in the same cycle, the clear is applied first and the event's bit changes win.
- R12: `dev_reg` loads `dev_addr` and marks the device valid from the next cycle on. A strobe in the same cycle is matched against the previous registration. Reads at offsets other than 0x18 and 0x1A return zero.
- R13: When plug and unplug strobes are both asserted in the same cycle, the plug is taken and the unplug is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_be | input | 2 | Byte enables of the write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| dev_reg | input | 1 | Register downstream device strobe |
| dev_addr | input | 16 | Address of device being registered |
| plug_evt | input | 1 | Device plugged strobe |
| unplug_evt | input | 1 | Device removed strobe |
| evt_addr | input | 16 | Address carried by plug/unplug |
| irq_en | input | 1 | External interrupt delivery enable |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The hardest situation to reach is a hot-plug event landing in the same cycle as a status clear or a control write. Interrupt gating then depends on values updated within that cycle. Random stimulus creates these collisions with strobes that fire often, with event addresses biased toward the registered one, and with control data drawn from the enable bits. Directed steps cover the rest: a strobe in the very cycle of registration, a clear and a plug together, and plug and unplug together.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
    localparam int DATA_W = 16;
    localparam int OFF_W  = 8;

    localparam logic [DATA_W-1:0] CTL_ABP_EN  = 16'h0001;
    localparam logic [DATA_W-1:0] CTL_PDC_EN  = 16'h0008;
    localparam logic [DATA_W-1:0] CTL_CC_EN   = 16'h0010;
    localparam logic [DATA_W-1:0] CTL_HP_EN   = 16'h0020;
    localparam logic [DATA_W-1:0] CTL_RESET   = 16'h03C0;

    localparam logic [DATA_W-1:0] STS_ABP     = 16'h0001;
    localparam logic [DATA_W-1:0] STS_PFD     = 16'h0002;
    localparam logic [DATA_W-1:0] STS_PDC     = 16'h0008;
    localparam logic [DATA_W-1:0] STS_CC      = 16'h0010;
    localparam logic [DATA_W-1:0] STS_PDS     = 16'h0040;
    localparam logic [DATA_W-1:0] STS_DLLSC   = 16'h0100;

    localparam logic [DATA_W-1:0] STS_W1C     = STS_ABP | STS_PFD | STS_PDC | STS_CC | STS_DLLSC;
    localparam logic [DATA_W-1:0] HP_CAUSES   = CTL_ABP_EN | CTL_PDC_EN;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] stat;
        logic              irq;
    } slot_state_t;
endpackage

// File: rtl/hp_dev_filter.sv
module hp_dev_filter #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_reg,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              plug_evt,
    input  logic              unplug_evt,
    input  logic [ADDR_W-1:0] evt_addr,
    output logic              plug_hit,
    output logic              unplug_hit,
    output logic              dev_valid
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } dev_t;

    dev_t dev_d, dev_q;
    logic addr_match;

    always_comb begin
        dev_d = dev_q;
        if (dev_reg) begin
            dev_d.valid = 1'b1;
            dev_d.addr  = dev_addr;
        end
        addr_match = dev_q.valid && (evt_addr == dev_q.addr);
        plug_hit   = addr_match && plug_evt;
        unplug_hit = addr_match && unplug_evt && !plug_evt;
        dev_valid  = dev_q.valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dev_q <= '0;
        else        dev_q <= dev_d;
    end
endmodule

// File: rtl/hp_reg_decode.sv
module hp_reg_decode
    import hp_slot_pkg::*;
#(
    parameter logic [OFF_W-1:0] CTRL_OFF = 8'h18,
    parameter logic [OFF_W-1:0] STAT_OFF = 8'h1A
) (
    input  logic              reg_wr,
    input  logic [OFF_W-1:0]  reg_addr,
    input  logic [1:0]        reg_be,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [DATA_W-1:0] stat_q,
    output logic              ctrl_load,
    output logic [DATA_W-1:0] stat_clr,
    output logic [DATA_W-1:0] rdata
);
    localparam int BYTE_W = DATA_W / 2;

    logic [DATA_W-1:0] byte_mask;

    always_comb begin
        byte_mask = {{BYTE_W{reg_be[1]}}, {BYTE_W{reg_be[0]}}};
        ctrl_load = reg_wr && (reg_addr == CTRL_OFF) && (reg_be == 2'b11)
                    && (reg_wdata != ctrl_q);
        stat_clr  = '0;
        if (reg_wr && (reg_addr == STAT_OFF))
            stat_clr = reg_wdata & byte_mask & STS_W1C;
        if (reg_addr == CTRL_OFF)      rdata = ctrl_q;
        else if (reg_addr == STAT_OFF) rdata = stat_q;
        else                           rdata = '0;
    end
endmodule

// File: rtl/hp_irq_gate.sv
module hp_irq_gate (
    input  logic irq_en,
    input  logic cc_evt,
    input  logic cc_en,
    input  logic hp_evt,
    input  logic hp_en,
    input  logic hp_cause,
    output logic irq_req
);
    logic cc_req, hp_req;

    always_comb begin
        cc_req  = cc_evt && cc_en;
        hp_req  = hp_evt && hp_en && hp_cause;
        irq_req = irq_en && (cc_req || hp_req);
    end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
    import hp_slot_pkg::*;
#(
    parameter int               ADDR_W   = 16,
    parameter logic [OFF_W-1:0] CTRL_OFF = 8'h18,
    parameter logic [OFF_W-1:0] STAT_OFF = 8'h1A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [OFF_W-1:0]  reg_addr,
    input  logic [1:0]        reg_be,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dev_reg,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              plug_evt,
    input  logic              unplug_evt,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic              irq_en,
    output logic              irq_pulse
);
    slot_state_t state_d, state_q;

    logic              plug_hit, unplug_hit, dev_valid_w;
    logic              ctrl_load;
    logic [DATA_W-1:0] stat_clr;
    logic              irq_req;
    logic              hp_evt;
    logic              hp_cause;
    logic [DATA_W-1:0] ctrl_q_w, stat_q_w;

    assign ctrl_q_w = state_q.ctrl;
    assign stat_q_w = state_q.stat;

    hp_dev_filter #(.ADDR_W(ADDR_W)) filt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_reg    (dev_reg),
        .dev_addr   (dev_addr),
        .plug_evt   (plug_evt),
        .unplug_evt (unplug_evt),
        .evt_addr   (evt_addr),
        .plug_hit   (plug_hit),
        .unplug_hit (unplug_hit),
        .dev_valid  (dev_valid_w)
    );

    hp_reg_decode #(.CTRL_OFF(CTRL_OFF), .STAT_OFF(STAT_OFF)) dec_i (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_be    (reg_be),
        .reg_wdata (reg_wdata),
        .ctrl_q    (state_q.ctrl),
        .stat_q    (state_q.stat),
        .ctrl_load (ctrl_load),
        .stat_clr  (stat_clr),
        .rdata     (reg_rdata)
    );

    hp_irq_gate gate_i (
        .irq_en   (irq_en),
        .cc_evt   (ctrl_load),
        .cc_en    (|(state_d.ctrl & CTL_CC_EN)),
        .hp_evt   (hp_evt),
        .hp_en    (|(state_d.ctrl & CTL_HP_EN)),
        .hp_cause (hp_cause),
        .irq_req  (irq_req)
    );

    always_comb begin
        state_d = state_q;
        hp_evt  = plug_hit || unplug_hit;
        if (ctrl_load) begin
            state_d.ctrl = reg_wdata;
            state_d.stat = state_d.stat | STS_CC;
        end
        state_d.stat = state_d.stat & ~stat_clr;
        if (plug_hit)
            state_d.stat = state_d.stat | STS_PDS | STS_PDC | STS_ABP;
        else if (unplug_hit)
            state_d.stat = (state_d.stat & ~STS_PDS) | STS_PDC | STS_ABP;
        hp_cause      = |(state_d.stat & state_d.ctrl & HP_CAUSES);
        state_d.irq   = irq_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.ctrl <= CTL_RESET;
            state_q.stat <= '0;
            state_q.irq  <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_pulse = state_q.irq;
endmodule

// File: rtl/hp_slot_chk.sv
module hp_slot_chk
    import hp_slot_pkg::*;
#(
    parameter logic [OFF_W-1:0] CTRL_OFF = 8'h18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [OFF_W-1:0]  reg_addr,
    input logic [1:0]        reg_be,
    input logic              plug_evt,
    input logic              unplug_evt,
    input logic              irq_en,
    input logic              irq_pulse,
    input logic [DATA_W-1:0] ctrl,
    input logic [DATA_W-1:0] stat,
    input logic              dev_valid
);
    AST_CTRL_WORD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl) |-> $past(reg_wr && (reg_be == 2'b11) && (reg_addr == CTRL_OFF))); // R2

    AST_CC_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl) |-> (stat & STS_CC) != 0); // R3

    AST_PDS_RISE_BY_PLUG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[6]) |-> $past(plug_evt)); // R5

    AST_PDS_FALL_BY_UNPLUG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat[6]) |-> $past(unplug_evt)); // R6

    AST_NO_DEV_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        ((plug_evt || unplug_evt) && !dev_valid) |=> $stable(stat[6])); // R7

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(irq_en)); // R9

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (stat & ~(STS_W1C | STS_PDS)) == 0); // R10
endmodule

bind hp_slot_ctrl hp_slot_chk #(.CTRL_OFF(CTRL_OFF)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_be     (reg_be),
    .plug_evt   (plug_evt),
    .unplug_evt (unplug_evt),
    .irq_en     (irq_en),
    .irq_pulse  (irq_pulse),
    .ctrl       (ctrl_q_w),
    .stat       (stat_q_w),
    .dev_valid  (dev_valid_w)
);

// File: tb/hp_slot_ctrl_tb.sv
module hp_slot_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CTRL = 8'h18;
    localparam logic [7:0] A_STAT = 8'h1A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h18;
    logic [1:0]  reg_be = 2'b00;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dev_reg = 1'b0;
    logic [15:0] dev_addr = '0;
    logic        plug_evt = 1'b0;
    logic        unplug_evt = 1'b0;
    logic [15:0] evt_addr = '0;
    logic        irq_en = 1'b0;
    logic        irq_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_ctrl = 16'h03C0;
    logic [15:0] m_stat = 16'h0000;
    logic        m_valid = 1'b0;
    logic [15:0] m_dev = '0;
    logic        m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hp_slot_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dev_reg(dev_reg), .dev_addr(dev_addr), .plug_evt(plug_evt),
        .unplug_evt(unplug_evt), .evt_addr(evt_addr), .irq_en(irq_en),
        .irq_pulse(irq_pulse)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected next state from the requirements
    task automatic model_step();
        logic [15:0] c, s;
        logic cc, hp, hit;
        c = m_ctrl; s = m_stat; cc = 0; hp = 0;
        if (reg_wr && reg_addr == A_CTRL && reg_be == 2'b11 && reg_wdata != m_ctrl) begin
            c = reg_wdata; s = s | 16'h0010; cc = 1;                  // R2 R3
        end
        if (reg_wr && reg_addr == A_STAT)
            s = s & ~(reg_wdata & 16'h011B & {{8{reg_be[1]}}, {8{reg_be[0]}}}); // R10
        hit = m_valid && (evt_addr == m_dev);                           // R7 R12
        if (plug_evt && hit) begin s = s | 16'h0049; hp = 1; end        // R5 R13
        else if (unplug_evt && hit) begin s = (s & ~16'h0040) | 16'h0009; hp = 1; end // R6
        m_irq = irq_en && ((cc && c[4]) || (hp && c[5] && ((s & c & 16'h0009) != 0))); // R4 R8 R9
        if (dev_reg) begin m_valid = 1; m_dev = dev_addr; end
        m_ctrl = c; m_stat = s;
    endtask

    task automatic step(input string tag, input logic wr, input logic [7:0] a,
                        input logic [1:0] be, input logic [15:0] wd,
                        input logic pl, input logic un, input logic [15:0] ea,
                        input logic dr, input logic [15:0] da, input logic ie);
        reg_wr = wr; reg_addr = a; reg_be = be; reg_wdata = wd;
        plug_evt = pl; unplug_evt = un; evt_addr = ea;
        dev_reg = dr; dev_addr = da; irq_en = ie;
        model_step();
        @(posedge clk); #1;
        reg_wr = 0; plug_evt = 0; unplug_evt = 0; dev_reg = 0;
        chk({tag, " irq"}, {15'd0, irq_pulse}, {15'd0, m_irq});
        reg_addr = A_CTRL; #1;
        chk({tag, " ctrl"}, reg_rdata, m_ctrl);
        reg_addr = A_STAT; #1;
        chk({tag, " stat"}, reg_rdata, m_stat);
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, A_CTRL, 2'b00, 16'h0, 0, 0, 16'h0, 0, 16'h0, irq_en);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 irq", {15'd0, irq_pulse}, 16'h0);
        reg_addr = A_CTRL; #1; chk("R1 ctrl", reg_rdata, 16'h03C0);
        reg_addr = A_STAT; #1; chk("R1 stat", reg_rdata, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        irq_en = 1'b1;

        step("R7 nodev", 0, A_CTRL, 2'b00, 16'h0, 1, 0, 16'h0042, 0, 16'h0, 1);
        step("R12 regsame", 0, A_CTRL, 2'b00, 16'h0, 1, 0, 16'h0042, 1, 16'h0042, 1);
        step("R2 partial", 1, A_CTRL, 2'b01, 16'h0039, 0, 0, 16'h0, 0, 16'h0, 1);
        step("R3 R4 change", 1, A_CTRL, 2'b11, 16'h03F9, 0, 0, 16'h0, 0, 16'h0, 1);
        idle("R9 single");
        step("R3 same", 1, A_CTRL, 2'b11, 16'h03F9, 0, 0, 16'h0, 0, 16'h0, 1);
        step("R10 clrall", 1, A_STAT, 2'b11, 16'hFFFF, 0, 0, 16'h0, 0, 16'h0, 1);
        step("R7 mismatch", 0, A_CTRL, 2'b00, 16'h0, 1, 0, 16'h0043, 0, 16'h0, 1);
        step("R5 R8 plug", 0, A_CTRL, 2'b00, 16'h0, 1, 0, 16'h0042, 0, 16'h0, 1);
        step("R10 pds ro", 1, A_STAT, 2'b11, 16'h0040, 0, 0, 16'h0, 0, 16'h0, 1);
        step("R10 lowbyte", 1, A_STAT, 2'b10, 16'h0009, 0, 0, 16'h0, 0, 16'h0, 1);
        step("R10 clr", 1, A_STAT, 2'b01, 16'h0009, 0, 0, 16'h0, 0, 16'h0, 1);
        step("R6 unplug", 0, A_CTRL, 2'b00, 16'h0, 0, 1, 16'h0042, 0, 16'h0, 1);
        step("R11 collide", 1, A_STAT, 2'b11, 16'h0009, 1, 0, 16'h0042, 0, 16'h0, 1);
        step("R9 irqoff", 0, A_CTRL, 2'b00, 16'h0, 0, 1, 16'h0042, 0, 16'h0, 0);
        step("R13 both", 0, A_CTRL, 2'b00, 16'h0, 1, 1, 16'h0042, 0, 16'h0, 1);
        step("R4 noccen", 1, A_CTRL, 2'b11, 16'h03C9, 0, 0, 16'h0, 0, 16'h0, 1);
        step("R8 nohpen", 0, A_CTRL, 2'b00, 16'h0, 0, 1, 16'h0042, 0, 16'h0, 1);
        reg_addr = 8'h10; #1; chk("R12 other offset", reg_rdata, 16'h0000);

        for (int i = 0; i < 3000; i++) begin
            logic [7:0]  a;
            logic [15:0] wd, ea;
            logic [1:0]  be;
            logic        dr;
            case ($urandom_range(0, 2))
                0: a = A_CTRL; 1: a = A_STAT; default: a = 8'h1C;
            endcase
            be = ($urandom_range(0, 3) != 0) ? 2'b11 : 2'($urandom_range(0, 3));
            wd = ($urandom_range(0, 3) == 0) ? m_ctrl : (16'h03C0 | 16'($urandom_range(0, 63)));
            if (a == A_STAT) wd = 16'($urandom);
            ea = ($urandom_range(0, 3) != 0) ? m_dev : 16'($urandom_range(0, 7));
            dr = ($urandom_range(0, 40) == 0);
            step("R3 R5 R6 R8 R11 random", $urandom_range(0, 1) == 1, a, be, wd,
                 $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0, ea,
                 dr, 16'($urandom_range(0, 7)), $urandom_range(0, 7) != 0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule